// File: doc/BRIEF.md
# Chained Expansion-Card Bus Port

This block is the per-card logic for one card on a peripheral expansion bus whose grant and interrupt acknowledges are chained from slot to slot. A bus-grant acknowledge enters on one pin and leaves on another. A card that wants the bus keeps the grant from reaching the cards further down the chain. It then holds the grant and drives a busy line until its transfer ends or a time-out expires. An expired time-out raises a fault indication.

The card also raises interrupts on exactly one of three prioritized request levels, chosen by a configuration input. Level 2 has the highest priority and the system side resolves priority between levels. Each level has its own acknowledge chain. While its interrupt is pending, the card blocks the acknowledge of its own level. When that acknowledge arrives, the card claims it and answers with a data-acknowledge while it drives an 8-bit vector on the data lines. Acknowledges on the other levels pass through combinationally. A separate fail output reports an internal failure of the card.

All bus-side signals are active low. Reset is synchronous and active high.

Top module: `card_bus_port`

## Requirements
- R1: While reset is held and at the first sample after it: busy_n=1, int_n=3'b111, dtack_n=1, data_oe=0, data_out=0, fail_n=1, fault_n=1.
- R2: When want_bus=0 and the card holds no grant, grant_out_n equals grant_in_n in the same cycle.
- R3: When want_bus=1 or the card holds the grant, grant_out_n=1. A clock edge that sees want_bus=1 and grant_in_n=0, while no grant and no fault is held, makes the card hold the grant, so busy_n=0 after that edge.
- R4: A held grant stays held when want_bus drops. A clock edge that sees xfer_done=1 releases it, so busy_n=1 after that edge and grant_out_n follows grant_in_n again.
- R5: If xfer_done is not seen, the grant is released after TMO_CYCLES edges of holding and fault_n goes to 0 at the same edge. While fault_n=0 the card takes no new grant. fault_n returns to 1 after an edge that sees grant_in_n=1.
- R6: cfg_level values 0, 1 and 2 select that request level. A value of 3 selects none. With a level selected, an edge that sees irq_req=1 and that level's iack_in_n bit at 1 makes the interrupt pending. Then int_n has 0 at bit cfg_level only and 1 on the other bits. With cfg_level=3, int_n stays 3'b111 and dtack_n stays 1.
- R7: iack_out_n[k] equals iack_in_n[k] in the same cycle for every level k, except the selected level while pending or claimed, where iack_out_n[k]=1.
- R8: An edge that sees a pending interrupt and iack_in_n[cfg_level]=0 claims it. After that edge dtack_n=0, data_oe=1 and data_out=vector. The claim holds while that acknowledge stays at 0, even if irq_req drops.
- R9: While claimed, an edge that sees iack_in_n[cfg_level]=1 ends the claim and clears the pending interrupt. After that edge dtack_n=1, data_oe=0, data_out=0 and int_n=3'b111.
- R10: fail_n is the inverse of card_fail, registered by one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| want_bus | input | 1 | Local request for bus ownership (level) |
| xfer_done | input | 1 | Local pulse: the owned transfer has finished |
| grant_in_n | input | 1 | Bus-grant acknowledge from the upstream card |
| grant_out_n | output | 1 | Bus-grant acknowledge to the downstream card |
| busy_n | output | 1 | Bus busy, driven while this card holds the grant |
| fault_n | output | 1 | Fault indication after a holding time-out |
| cfg_level | input | 2 | Interrupt level select: 0..2, or 3 for none |
| irq_req | input | 1 | Local interrupt request |
| vector | input | 8 | Interrupt vector returned on acknowledge |
| iack_in_n | input | 3 | Per-level interrupt acknowledges from upstream |
| iack_out_n | output | 3 | Per-level interrupt acknowledges to downstream |
| int_n | output | 3 | This card's contribution to the three request levels |
| dtack_n | output | 1 | Data-acknowledge answering a claimed interrupt |
| data_out | output | 8 | Vector on the data lines while claimed, otherwise zero |
| data_oe | output | 1 | Data-line drive enable |
| card_fail | input | 1 | Local failure indication |
| fail_n | output | 1 | Card fail output |

## Verification
The bus-grant hold and the interrupt claim run in separate state machines, so both can be active in the same cycle. The end of a transfer and the release of an acknowledge can also land on one clock edge. The bench holds the grant with an interrupt pending and then asserts the card's level acknowledge. It checks that busy_n and dtack_n are both at 0. It then pulses xfer_done at the same edge that releases the acknowledge, and checks that busy_n and dtack_n both return to 1 and that neither chain leaves the other's state changed.

// File: rtl/card_bus_pkg.sv
package card_bus_pkg;

    localparam int NUM_LEVELS = 3;
    localparam int LVL_W      = 2;

    // bus-grant side state
    typedef struct packed {
        logic hold;
        logic fault;
    } grant_st_t;

    // interrupt side state
    typedef struct packed {
        logic pend;
        logic claim;
    } irq_st_t;

    function automatic logic level_hit(input logic [LVL_W-1:0] cfg, input int idx);
        return (int'(cfg) == idx);
    endfunction

endpackage

// File: rtl/grant_link.sv
module grant_link
    import card_bus_pkg::*;
#(
    parameter int TMO_CYCLES = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic want_bus,
    input  logic xfer_done,
    input  logic grant_in_n,
    output logic grant_out_n,
    output logic busy_n,
    output logic fault_n
);

    localparam int CNT_W = (TMO_CYCLES > 1) ? $clog2(TMO_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TMO_CYCLES - 1);

    grant_st_t        st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (st_q.hold) begin
            if (xfer_done) begin
                st_d.hold = 1'b0;
                cnt_d     = '0;
            end else if (cnt_q == CNT_LAST) begin
                st_d.hold  = 1'b0;
                st_d.fault = 1'b1;
                cnt_d      = '0;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end else begin
            if (st_q.fault && grant_in_n) begin
                st_d.fault = 1'b0;
            end
            if (want_bus && !grant_in_n && !st_q.fault) begin
                st_d.hold = 1'b1;
                cnt_d     = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= '0;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    assign grant_out_n = (want_bus || st_q.hold) ? 1'b1 : grant_in_n;
    assign busy_n      = ~st_q.hold;
    assign fault_n     = ~st_q.fault;

    assert_busy_blocks_R3: assert property (@(posedge clk) disable iff (rst)
        !busy_n |-> grant_out_n);

    assert_done_release_R4: assert property (@(posedge clk) disable iff (rst)
        (st_q.hold && xfer_done) |=> busy_n);

    assert_fault_drops_grant_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(fault_n) |-> busy_n);

    assert_no_grant_in_fault_R5: assert property (@(posedge clk) disable iff (rst)
        !fault_n |-> busy_n);

endmodule

// File: rtl/irq_link.sv
module irq_link
    import card_bus_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [LVL_W-1:0]      cfg_level,
    input  logic                  irq_req,
    input  logic [VEC_W-1:0]      vector,
    input  logic [NUM_LEVELS-1:0] iack_in_n,
    output logic [NUM_LEVELS-1:0] iack_out_n,
    output logic [NUM_LEVELS-1:0] int_n,
    output logic                  dtack_n,
    output logic [VEC_W-1:0]      data_out,
    output logic                  data_oe
);

    irq_st_t               st_q, st_d;
    logic [NUM_LEVELS-1:0] sel;
    logic                  cfg_ok;
    logic                  my_ack;

    for (genvar k = 0; k < NUM_LEVELS; k++) begin : g_lvl
        assign sel[k]        = level_hit(cfg_level, k);
        assign iack_out_n[k] = (sel[k] && (st_q.pend || st_q.claim)) ? 1'b1 : iack_in_n[k];
        assign int_n[k]      = ~(sel[k] && st_q.pend);
    end

    assign cfg_ok = |sel;
    assign my_ack = |(sel & ~iack_in_n);

    always_comb begin
        st_d = st_q;
        if (!st_q.pend) begin
            if (irq_req && cfg_ok && !my_ack) begin
                st_d.pend = 1'b1;
            end
        end else if (!st_q.claim) begin
            if (my_ack) begin
                st_d.claim = 1'b1;
            end
        end else if (!my_ack) begin
            st_d.claim = 1'b0;
            st_d.pend  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dtack_n  = ~st_q.claim;
    assign data_oe  = st_q.claim;
    assign data_out = st_q.claim ? vector : '0;

    assert_single_level_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~int_n));

    assert_claim_needs_pend_R8: assert property (@(posedge clk) disable iff (rst)
        !dtack_n |-> (int_n != '1));

    assert_claim_blocks_chain_R7: assert property (@(posedge clk) disable iff (rst)
        !dtack_n |-> ((iack_out_n | ~sel) == '1));

    assert_release_clears_R9: assert property (@(posedge clk) disable iff (rst)
        (st_q.claim && !my_ack) |=> (dtack_n && int_n == '1));

endmodule

// File: rtl/card_bus_port.sv
module card_bus_port
    import card_bus_pkg::*;
#(
    parameter int TMO_CYCLES = 64,
    parameter int VEC_W      = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  want_bus,
    input  logic                  xfer_done,
    input  logic                  grant_in_n,
    output logic                  grant_out_n,
    output logic                  busy_n,
    output logic                  fault_n,
    input  logic [LVL_W-1:0]      cfg_level,
    input  logic                  irq_req,
    input  logic [VEC_W-1:0]      vector,
    input  logic [NUM_LEVELS-1:0] iack_in_n,
    output logic [NUM_LEVELS-1:0] iack_out_n,
    output logic [NUM_LEVELS-1:0] int_n,
    output logic                  dtack_n,
    output logic [VEC_W-1:0]      data_out,
    output logic                  data_oe,
    input  logic                  card_fail,
    output logic                  fail_n
);

    logic fail_q;

    grant_link #(.TMO_CYCLES(TMO_CYCLES)) grant_i (
        .clk         (clk),
        .rst         (rst),
        .want_bus    (want_bus),
        .xfer_done   (xfer_done),
        .grant_in_n  (grant_in_n),
        .grant_out_n (grant_out_n),
        .busy_n      (busy_n),
        .fault_n     (fault_n)
    );

    irq_link #(.VEC_W(VEC_W)) irq_i (
        .clk        (clk),
        .rst        (rst),
        .cfg_level  (cfg_level),
        .irq_req    (irq_req),
        .vector     (vector),
        .iack_in_n  (iack_in_n),
        .iack_out_n (iack_out_n),
        .int_n      (int_n),
        .dtack_n    (dtack_n),
        .data_out   (data_out),
        .data_oe    (data_oe)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fail_q <= 1'b0;
        end else begin
            fail_q <= card_fail;
        end
    end

    assign fail_n = ~fail_q;

endmodule

// File: tb/card_bus_port_tb.sv
`timescale 1ns/1ps
module card_bus_port_tb_top;

    localparam int TMO = 6;

    logic       clk = 1'b0;
    logic       rst;
    logic       want_bus, xfer_done, grant_in_n;
    logic       grant_out_n, busy_n, fault_n;
    logic [1:0] cfg_level;
    logic       irq_req;
    logic [7:0] vector;
    logic [2:0] iack_in_n, iack_out_n, int_n;
    logic       dtack_n, data_oe;
    logic [7:0] data_out;
    logic       card_fail, fail_n;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    card_bus_port #(.TMO_CYCLES(TMO), .VEC_W(8)) dut_i (
        .clk(clk), .rst(rst), .want_bus(want_bus), .xfer_done(xfer_done),
        .grant_in_n(grant_in_n), .grant_out_n(grant_out_n), .busy_n(busy_n),
        .fault_n(fault_n), .cfg_level(cfg_level), .irq_req(irq_req),
        .vector(vector), .iack_in_n(iack_in_n), .iack_out_n(iack_out_n),
        .int_n(int_n), .dtack_n(dtack_n), .data_out(data_out),
        .data_oe(data_oe), .card_fail(card_fail), .fail_n(fail_n)
    );

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #800000;
        errors++;
        checks++;
        $display("FAIL watchdog: run hung");
        summary();
    end

    initial begin
        rst = 1'b1; want_bus = 0; xfer_done = 0; grant_in_n = 1;
        cfg_level = 2'd0; irq_req = 0; vector = 8'h00; iack_in_n = 3'b111; card_fail = 0;
        step(); step();
        // R1 reset state
        chk({15'd0, busy_n}, 16'd1, "R1 busy_n");
        chk({13'd0, int_n}, 16'h7, "R1 int_n");
        chk({15'd0, dtack_n}, 16'd1, "R1 dtack_n");
        chk({7'd0, data_oe, data_out}, 16'h0, "R1 data");
        chk({14'd0, fail_n, fault_n}, 16'h3, "R1 fail/fault");
        rst = 1'b0;
        step();
        chk({13'd0, busy_n, int_n[0], dtack_n}, 16'h7, "R1 after release");

        // R2 pass-through sweep
        for (int g = 0; g < 2; g++) begin
            grant_in_n = g[0];
            #0.2;
            chk({15'd0, grant_out_n}, 16'(g), "R2 pass");
        end
        // R3 blocking while wanting, upstream idle
        grant_in_n = 1; want_bus = 1; #0.2;
        chk({15'd0, grant_out_n}, 16'd1, "R3 block idle");
        step();
        chk({15'd0, busy_n}, 16'd1, "R3 no take without grant");
        grant_in_n = 0; #0.2;
        chk({15'd0, grant_out_n}, 16'd1, "R3 block on grant");
        step();
        chk({15'd0, busy_n}, 16'd0, "R3 take");
        // R4 hold after want drops
        want_bus = 0;
        step(); step();
        chk({14'd0, busy_n, grant_out_n}, 16'h1, "R4 hold kept");
        xfer_done = 1;
        step();
        xfer_done = 0; #0.2;
        chk({15'd0, busy_n}, 16'd1, "R4 released");
        chk({15'd0, grant_out_n}, 16'd0, "R4 pass resumes");

        // R5 time-out
        want_bus = 1; grant_in_n = 0;
        step();
        want_bus = 0;
        chk({15'd0, busy_n}, 16'd0, "R5 take");
        for (int i = 0; i < TMO - 1; i++) step();
        chk({14'd0, busy_n, fault_n}, 16'h1, "R5 still held");
        step();
        chk({14'd0, busy_n, fault_n}, 16'h2, "R5 timeout fault");
        want_bus = 1;
        step();
        chk({14'd0, busy_n, fault_n}, 16'h2, "R5 no retake in fault");
        want_bus = 0; grant_in_n = 1;
        step();
        chk({15'd0, fault_n}, 16'd1, "R5 fault cleared");

        // R6..R9 sweep over every level setting
        for (int lvl = 0; lvl < 4; lvl++) begin
            logic [2:0] mask;
            logic [7:0] v;
            mask = (lvl < 3) ? 3'(1 << lvl) : 3'b000;
            v = 8'h3C ^ 8'(lvl * 8'h51);
            cfg_level = 2'(lvl); vector = v; iack_in_n = 3'b111; irq_req = 1;
            step();
            chk({13'd0, int_n}, {13'd0, ~mask}, "R6 int_n level");
            for (int p = 0; p < 8; p++) begin
                iack_in_n = 3'(p);
                #0.1;
                chk({13'd0, iack_out_n}, {13'd0, 3'(p) | mask}, "R7 chain");
            end
            iack_in_n = ~mask;
            if (lvl == 3) iack_in_n = 3'b110;
            irq_req = 0;
            step();
            if (lvl < 3) begin
                chk({7'd0, dtack_n, data_out}, {7'd0, 1'b0, v}, "R8 claim vector");
                chk({15'd0, data_oe}, 16'd1, "R8 oe");
            end else begin
                chk({7'd0, dtack_n, data_out}, 16'h100, "R6 none never claims");
                chk({13'd0, iack_out_n}, 16'h6, "R7 none passes");
            end
            step();
            if (lvl < 3) chk({15'd0, dtack_n}, 16'd0, "R8 claim held");
            iack_in_n = 3'b111;
            step();
            chk({13'd0, int_n}, 16'h7, "R9 int cleared");
            chk({7'd0, dtack_n, data_out}, 16'h100, "R9 dtack released");
            chk({15'd0, data_oe}, 16'd0, "R9 oe off");
        end

        // R10 fail
        card_fail = 1;
        step();
        chk({15'd0, fail_n}, 16'd0, "R10 fail set");
        card_fail = 0;
        step();
        chk({15'd0, fail_n}, 16'd1, "R10 fail clear");

        // grant hold and interrupt claim in the same cycles (R4, R8, R9)
        cfg_level = 2'd2; vector = 8'hA5; irq_req = 1; want_bus = 1; grant_in_n = 0;
        step();
        want_bus = 0; irq_req = 0;
        chk({12'd0, busy_n, int_n}, 16'h3, "R3 R6 together");
        iack_in_n = 3'b011;
        step();
        chk({7'd0, dtack_n, data_out}, 16'h0A5, "R8 with grant held");
        chk({15'd0, busy_n}, 16'd0, "R4 with claim");
        xfer_done = 1; iack_in_n = 3'b111;
        step();
        xfer_done = 0; grant_in_n = 1; #0.2;
        chk({14'd0, busy_n, dtack_n}, 16'h3, "R4 R9 same edge");
        chk({12'd0, grant_out_n, iack_out_n}, 16'hF, "R2 R7 after both");

        summary();
    end

endmodule